// File: doc/BRIEF.md
# User-Level Timer Access Trap Checker

This block decides whether an access made at the least privileged exception level (level 0) to one of the system timer or counter registers must be trapped, and to which higher level the trap is taken. Each request names the register group being touched, the level the access is made from, a 10-bit timer control word that holds four access-enable bits, and two hypervisor flags: a host-mode flag and a trap-routing flag. The block answers with a trap flag and a 2-bit destination level.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` is low, so no new request is taken. When the consumer is ready, a new request can be taken on the same edge that the old result leaves, which gives one result per cycle.

Register group codes on `in_target`: 0 physical timer (control, compare, timer value), 1 virtual timer (same three registers), 2 physical count, 3 virtual count, 4 counter frequency. Codes 5 to 7 name no timer register.

Top module: `utrap_checker`

## Requirements
- R1: A level-0 access to group 0 (physical timer) traps when `ctl_word[9]` is 0, and does not trap when it is 1.
- R2: A level-0 access to group 1 (virtual timer) traps when `ctl_word[8]` is 0, and does not trap when it is 1.
- R3: A level-0 access to group 2 (physical count) traps exactly when `ctl_word[0]` is 0. A level-0 access to group 3 (virtual count) traps exactly when `ctl_word[1]` is 0.
- R4: A level-0 access to group 4 (frequency) traps only when `ctl_word[0]` and `ctl_word[1]` are both 0.
- R5: A trapped access reports `out_level` 1 when `route_flag` is 0 and 2 when it is 1. A result with no trap reports `out_level` 0.
- R6: When `host_flag` and `route_flag` are both 1, no access traps, whatever the enable bits hold.
- R7: Accesses made at levels 1 to 3 never trap, and group codes 5 to 7 never trap. Bits 2 to 7 of `ctl_word` affect no result.
- R8: The result of a request taken on a clock edge is on `out_trap`, `out_level` and `out_valid` after that edge. `out_valid` falls after an edge where `out_ready` is high and no new request is taken.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_trap` and `out_level` hold their values.
- R10: While reset is held, and after its release until the first request is taken, `out_valid`, `out_trap` and `out_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_target | input | 3 | Register group code of the access |
| in_level | input | 2 | Exception level the access is made from |
| ctl_word | input | 10 | Timer control word; enables at bits 0, 1, 8, 9 |
| host_flag | input | 1 | Hypervisor host-mode flag |
| route_flag | input | 1 | Routes traps to level 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_trap | output | 1 | The access must trap |
| out_level | output | 2 | Destination level of the trap, 0 when none |

## Verification
On every cycle the assertions check the handshake: that a taken request yields a valid result next cycle, that a stalled result stays frozen with the input closed, that the trap flag and destination level agree, and that accesses from higher levels, host mode and a frequency access with either count enable set never leave a trap behind. The per-group enable decoding, the exact routing destination for each flag setting and the indifference to the unused control bits can only be shown by the bench's sweep, which drives every group code, level, enable pattern and flag pair and compares against an arithmetic model.

// File: rtl/utrap_pkg.sv
package utrap_pkg;

  localparam int unsigned TGT_W = 3;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned CTL_W = 10;

  // Positions of the enable bits inside the control word.
  localparam int unsigned POS_PCOUNT = 0;
  localparam int unsigned POS_VCOUNT = 1;
  localparam int unsigned POS_VTIMER = 8;
  localparam int unsigned POS_PTIMER = 9;

  typedef enum logic [TGT_W-1:0] {
    GRP_PTIMER = 3'd0,
    GRP_VTIMER = 3'd1,
    GRP_PCOUNT = 3'd2,
    GRP_VCOUNT = 3'd3,
    GRP_FREQ   = 3'd4
  } grp_e;

  localparam logic [LVL_W-1:0] LVL_USER  = 2'd0;
  localparam logic [LVL_W-1:0] LVL_KERN  = 2'd1;
  localparam logic [LVL_W-1:0] LVL_HYP   = 2'd2;

  typedef struct packed {
    logic             trap;
    logic [LVL_W-1:0] level;
  } verdict_t;

  localparam int unsigned VERDICT_W = $bits(verdict_t);

endpackage

// File: rtl/utrap_decode.sv
// Maps a register group to the enable bits that open it and reports whether
// the access is blocked by the control word alone (no level or mode gating).
module utrap_decode
  import utrap_pkg::*;
(
  input  logic [TGT_W-1:0] target,
  input  logic             en_pcount,
  input  logic             en_vcount,
  input  logic             en_vtimer,
  input  logic             en_ptimer,
  output logic             blocked
);

  always_comb begin
    blocked = 1'b0;
    case (target)
      GRP_PTIMER: blocked = ~en_ptimer;
      GRP_VTIMER: blocked = ~en_vtimer;
      GRP_PCOUNT: blocked = ~en_pcount;
      GRP_VCOUNT: blocked = ~en_vcount;
      // Frequency is reachable through either count enable.
      GRP_FREQ:   blocked = ~(en_pcount | en_vcount);
      default:    blocked = 1'b0;
    endcase
  end

endmodule

// File: rtl/utrap_route.sv
// Applies level and host-mode gating to a blocked access and picks the
// destination level of the resulting trap.
module utrap_route
  import utrap_pkg::*;
(
  input  logic             blocked,
  input  logic [LVL_W-1:0] level,
  input  logic             host_flag,
  input  logic             route_flag,
  output verdict_t         verdict
);

  logic from_user;
  logic host_mode;

  assign from_user = (level == LVL_USER);
  assign host_mode = host_flag & route_flag;

  always_comb begin
    verdict.trap  = blocked & from_user & ~host_mode;
    verdict.level = LVL_USER;
    if (verdict.trap) begin
      verdict.level = route_flag ? LVL_HYP : LVL_KERN;
    end
  end

endmodule

// File: rtl/utrap_outreg.sv
// Single-entry valid/ready output register.
module utrap_outreg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic take;

  assign up_ready = ~dn_valid | dn_ready;
  assign take     = up_valid & up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (take) begin
        dn_valid <= 1'b1;
        dn_data  <= up_data;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/utrap_checker.sv
module utrap_checker
  import utrap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_target,
  input  logic [1:0]       in_level,
  input  logic [9:0]       ctl_word,
  input  logic             host_flag,
  input  logic             route_flag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_trap,
  output logic [1:0]       out_level
);

  logic     blocked;
  verdict_t verdict_c;
  verdict_t verdict_q;
  logic     unused_ctl;

  assign unused_ctl = ^ctl_word[POS_VTIMER-1:POS_VCOUNT+1];

  utrap_decode u_decode (
    .target    (in_target),
    .en_pcount (ctl_word[POS_PCOUNT]),
    .en_vcount (ctl_word[POS_VCOUNT]),
    .en_vtimer (ctl_word[POS_VTIMER]),
    .en_ptimer (ctl_word[POS_PTIMER]),
    .blocked   (blocked)
  );

  utrap_route u_route (
    .blocked    (blocked),
    .level      (in_level),
    .host_flag  (host_flag),
    .route_flag (route_flag),
    .verdict    (verdict_c)
  );

  utrap_outreg #(.W(VERDICT_W)) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (verdict_c),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (verdict_q)
  );

  assign out_trap  = verdict_q.trap;
  assign out_level = verdict_q.level;

endmodule

// File: rtl/utrap_checker_sva.sv
module utrap_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_target,
  input logic [1:0] in_level,
  input logic [9:0] ctl_word,
  input logic       host_flag,
  input logic       route_flag,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_trap,
  input logic [1:0] out_level
);

  logic took;
  assign took = in_valid & in_ready;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_trap && out_level == 2'd0)); // R10

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_trap) && $stable(out_level))); // R9

  AST_STALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trap == (out_level != 2'd0)) && (out_level != 2'd3)); // R5

  AST_ROUTE_HYP: assert property (@(posedge clk) disable iff (!rst_n)
    (took && route_flag) |=> (out_level != 2'd1)); // R5

  AST_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_level != 2'd0) |=> !out_trap); // R7

  AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (took && host_flag && route_flag) |=> !out_trap); // R6

  AST_FREQ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_target == 3'd4 && (ctl_word[0] || ctl_word[1])) |=> !out_trap); // R4

endmodule

bind utrap_checker utrap_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_target  (in_target),
  .in_level   (in_level),
  .ctl_word   (ctl_word),
  .host_flag  (host_flag),
  .route_flag (route_flag),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_trap   (out_trap),
  .out_level  (out_level)
);

// File: tb/utrap_checker_tb.sv
`timescale 1ns/1ps
module utrap_checker_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [2:0] in_target;
  logic [1:0] in_level;
  logic [9:0] ctl_word;
  logic       host_flag;
  logic       route_flag;
  logic       out_valid;
  logic       out_ready;
  logic       out_trap;
  logic [1:0] out_level;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  utrap_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_level(in_level), .ctl_word(ctl_word),
    .host_flag(host_flag), .route_flag(route_flag), .out_valid(out_valid),
    .out_ready(out_ready), .out_trap(out_trap), .out_level(out_level)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_trap(int t, int l, logic [9:0] c, int h, int r);
    if (l != 0) return 0;
    if (h == 1 && r == 1) return 0;
    case (t)
      0: return 1 - int'(c[9]);
      1: return 1 - int'(c[8]);
      2: return 1 - int'(c[0]);
      3: return 1 - int'(c[1]);
      4: return (int'(c[0]) + int'(c[1]) == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_tag(int t, int l, int h, int r);
    if (l != 0 || t > 4) return "R7";
    if (h == 1 && r == 1) return "R6";
    case (t)
      0: return "R1";
      1: return "R2";
      4: return "R4";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_target = '0; in_level = '0;
    ctl_word = '0; host_flag = 1'b0; route_flag = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 valid in reset", int'(out_valid), 0);
    check("R10 trap in reset", int'(out_trap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after release", int'(out_valid), 0);
    check("R10 level after release", int'(out_level), 0);

    // Exhaustive sweep: R1..R7 decode, R5 routing, R8 timing.
    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 4; l++)
        for (int e = 0; e < 16; e++)
          for (int f = 0; f < 4; f++) begin
            int et;
            int el;
            logic [9:0] c;
            c = {e[3], e[2], 6'(e * 11 + t), e[1], e[0]};
            in_target = 3'(t); in_level = 2'(l); ctl_word = c;
            host_flag = f[1]; route_flag = f[0]; in_valid = 1'b1;
            @(negedge clk);
            et = model_trap(t, l, c, int'(f[1]), int'(f[0]));
            el = (et == 0) ? 0 : (f[0] ? 2 : 1);
            check("R8 valid after take", int'(out_valid), 1);
            check(req_tag(t, l, int'(f[1]), int'(f[0])), int'(out_trap), et);
            check("R5 level", int'(out_level), el);
          end

    // R8: valid falls with no new request.
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 valid drop", int'(out_valid), 0);

    // R9: back-pressure. First a trapping request routed to level 2.
    out_ready = 1'b0;
    in_target = 3'd0; in_level = 2'd0; ctl_word = '0;
    host_flag = 1'b0; route_flag = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 first held valid", int'(out_valid), 1);
    check("R9 input closed", int'(in_ready), 0);
    // Second request would give no trap.
    ctl_word = 10'h3FF; route_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 trap held", int'(out_trap), 1);
    check("R9 level held", int'(out_level), 2);
    check("R9 still closed", int'(in_ready), 0);
    out_ready = 1'b1;
    #1;
    check("R9 open when consumer ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result trap", int'(out_trap), 0);
    check("R9 second result level", int'(out_level), 0);
    check("R8 second valid", int'(out_valid), 1);
    @(negedge clk);
    check("R8 valid cleared", int'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule